// File: doc/BRIEF.md
# Display Command Byte Parser

This block sits behind a serial byte receiver on a small display controller. Bytes arrive one at a time with a valid strobe. A select line says how each byte is meant. While the select line is low, the byte belongs to the command stream. While it is high, the byte is pixel data that goes to the framebuffer path, and this parser ignores it. In the command stream the parser takes an opcode byte and works out how many argument bytes that opcode needs. It gathers those bytes, then acts on the complete set.

Three commands change state. A column-window command sets the first and last column. A row-window command sets the first and last row. A remap command stores a mode byte, and one bit of that byte selects vertical address increment. Window arguments are reduced modulo the column count and modulo the row count. When a window command completes, a one-cycle load strobe tells the framebuffer addressing logic to reload its current position from the new start value.

Many other opcodes, such as analog, timing and power settings, are accepted, their arguments are consumed, and they are then dropped. An opcode the parser does not know finishes at once and sets a sticky error flag. Raising the select line aborts a command whose arguments are only partly collected.

Top module: `dcp_parser`

## Requirements
- R1: After reset, the window outputs are as follows: column start 0, column end COLS-1 (63), row start 0, row end ROWS-1 (79). The remap register is 0, both load strobes are low and the error flag is low.
- R2: Opcode 0x15 followed by two argument bytes sets column start to the first argument mod COLS and column end to the second argument mod COLS. The outputs change, and col_load is high, in the cycle after the clock edge that takes the second argument.
- R3: Opcode 0x75 followed by two argument bytes sets row start to the first argument mod ROWS and row end to the second argument mod ROWS. The outputs change, and row_load is high, in the cycle after the clock edge that takes the second argument.
- R4: Opcode 0xA0 followed by one argument byte stores that byte in the remap register. vert_inc equals bit VERT_BIT (2) of that byte.
- R5: Each of the opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF consumes exactly one argument byte and changes no output. The byte after that argument is decoded as an opcode.
- R6: Opcode 0xB8 consumes exactly eight argument bytes and changes no output, even when those bytes equal opcode values.
- R7: Opcodes 0x84, 0x85, 0x86, 0xA4, 0xA5, 0xA6, 0xA7, 0xAE, 0xAF and 0xE3 take no argument. The next byte is decoded as an opcode.
- R8: Opcode 0xFF takes no argument, changes no output and does not set the error flag.
- R9: Any other opcode takes no argument and sets bad_op. bad_op stays high until reset.
- R10: Bytes sent while sel_data is high change no parser output. Raising sel_data while a command is partly collected discards it, and the next command byte is decoded as an opcode.
- R11: col_load and row_load are single-cycle pulses, one for each completed window command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_dat | input | 8 | Received byte |
| sel_data | input | 1 | 0: command stream, 1: pixel data (ignored here) |
| col_lo | output | CW (6) | Column window start |
| col_hi | output | CW (6) | Column window end |
| row_lo | output | RW (7) | Row window start |
| row_hi | output | RW (7) | Row window end |
| remap | output | 8 | Stored remap byte |
| vert_inc | output | 1 | Vertical increment mode bit of the remap byte |
| col_load | output | 1 | One-cycle strobe: column window reloaded |
| row_load | output | 1 | One-cycle strobe: row window reloaded |
| bad_op | output | 1 | Sticky flag: unknown opcode seen |

## Verification
The internal state that matters is the argument counter, and it can only be seen at the ports through how the bytes that follow are read. If the counter is off by one, an argument is decoded as an opcode, or an opcode is swallowed as an argument. Each skip test therefore follows the opcode under test with a remap command whose payload differs from any window value. The test then checks remap, the window outputs and the strobes one cycle after the last byte. Any framing slip shows up there within a single command. Modulo reduction is tested with arguments above both the column count and the row count.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
   localparam int CNT_W = 4;

   typedef enum logic [1:0] {
      K_NONE  = 2'd0,
      K_COL   = 2'd1,
      K_ROW   = 2'd2,
      K_REMAP = 2'd3
   } op_kind_t;
endpackage

// File: rtl/dcp_decode.sv
module dcp_decode
   import dcp_pkg::*;
(
   input  logic [7:0]       op,
   output op_kind_t         kind,
   output logic [CNT_W-1:0] nargs,
   output logic             unknown
);
   always_comb begin
      kind    = K_NONE;
      nargs   = '0;
      unknown = 1'b0;
      case (op)
         8'h15: begin kind = K_COL;   nargs = CNT_W'(2); end
         8'h75: begin kind = K_ROW;   nargs = CNT_W'(2); end
         8'hA0: begin kind = K_REMAP; nargs = CNT_W'(1); end
         8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1, 8'hB2, 8'hB3,
         8'hBC, 8'hBE, 8'hBF: nargs = CNT_W'(1);
         8'hB8: nargs = CNT_W'(8);
         8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
         8'hAE, 8'hAF, 8'hE3, 8'hFF: nargs = '0;
         default: unknown = 1'b1;
      endcase
   end
endmodule

// File: rtl/dcp_seq.sv
module dcp_seq
   import dcp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_vld,
   input  logic [7:0] byte_dat,
   input  logic       sel_data,
   output logic       commit,
   output op_kind_t   commit_kind,
   output logic [7:0] arg_a,
   output logic [7:0] arg_b,
   output logic       bad_op
);
   logic             busy_q;
   op_kind_t         kind_q;
   logic [CNT_W-1:0] need_q, cnt_q;
   logic [7:0]       arg0_q;
   op_kind_t         dec_kind;
   logic [CNT_W-1:0] dec_nargs;
   logic             dec_unk;
   logic             acc, last_arg;

   dcp_decode u_dec (
      .op      (byte_dat),
      .kind    (dec_kind),
      .nargs   (dec_nargs),
      .unknown (dec_unk)
   );

   assign acc         = byte_vld && !sel_data;
   assign last_arg    = (cnt_q + CNT_W'(1)) == need_q;
   assign commit      = acc && busy_q && last_arg;
   assign commit_kind = kind_q;
   assign arg_a       = (cnt_q == '0) ? byte_dat : arg0_q;
   assign arg_b       = byte_dat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         kind_q <= K_NONE;
         need_q <= '0;
         cnt_q  <= '0;
         arg0_q <= '0;
         bad_op <= 1'b0;
      end else if (sel_data) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (byte_vld) begin
         if (!busy_q) begin
            if (dec_unk) bad_op <= 1'b1;
            busy_q <= (dec_nargs != '0);
            kind_q <= dec_kind;
            need_q <= dec_nargs;
            cnt_q  <= '0;
         end else begin
            if (cnt_q == '0) arg0_q <= byte_dat;
            if (last_arg) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   // R9
   bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op |=> bad_op);
   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q < need_q));
   // R10
   sel_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_data |=> !busy_q);
endmodule

// File: rtl/dcp_wrap.sv
module dcp_wrap #(
   parameter int N = 64,
   localparam int W = $clog2(N)
) (
   input  logic [7:0]   din,
   output logic [W-1:0] dout
);
   generate
      if ((N & (N - 1)) == 0) begin : g_pow2
         assign dout = din[W-1:0];
      end else begin : g_mod
         logic [7:0] rem;
         assign rem  = din % 8'(N);
         assign dout = rem[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/dcp_regs.sv
module dcp_regs
   import dcp_pkg::*;
#(
   parameter int COLS     = 64,
   parameter int ROWS     = 80,
   parameter int VERT_BIT = 2,
   localparam int CW = $clog2(COLS),
   localparam int RW = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  op_kind_t      kind,
   input  logic [7:0]    arg_a,
   input  logic [7:0]    arg_b,
   output logic [CW-1:0] col_lo,
   output logic [CW-1:0] col_hi,
   output logic [RW-1:0] row_lo,
   output logic [RW-1:0] row_hi,
   output logic [7:0]    remap,
   output logic          vert_inc,
   output logic          col_load,
   output logic          row_load
);
   logic [CW-1:0] ca, cb;
   logic [RW-1:0] ra, rb;

   dcp_wrap #(.N(COLS)) u_ca (.din(arg_a), .dout(ca));
   dcp_wrap #(.N(COLS)) u_cb (.din(arg_b), .dout(cb));
   dcp_wrap #(.N(ROWS)) u_ra (.din(arg_a), .dout(ra));
   dcp_wrap #(.N(ROWS)) u_rb (.din(arg_b), .dout(rb));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_lo   <= '0;
         col_hi   <= CW'(COLS - 1);
         row_lo   <= '0;
         row_hi   <= RW'(ROWS - 1);
         remap    <= '0;
         col_load <= 1'b0;
         row_load <= 1'b0;
      end else begin
         col_load <= commit && (kind == K_COL);
         row_load <= commit && (kind == K_ROW);
         if (commit) begin
            case (kind)
               K_COL:   begin col_lo <= ca; col_hi <= cb; end
               K_ROW:   begin row_lo <= ra; row_hi <= rb; end
               K_REMAP: remap <= arg_b;
               default: ;
            endcase
         end
      end
   end

   assign vert_inc = remap[VERT_BIT];

   // R11
   col_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_load |=> !col_load);
   // R11
   row_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_load |=> !row_load);
   // R2
   col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !col_load |-> ($stable(col_lo) && $stable(col_hi)));
   // R3
   row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_lo < RW'(ROWS)) && (row_hi < RW'(ROWS)));
endmodule

// File: rtl/dcp_parser.sv
module dcp_parser
   import dcp_pkg::*;
#(
   parameter int COLS     = 64,
   parameter int ROWS     = 80,
   parameter int VERT_BIT = 2,
   localparam int CW = $clog2(COLS),
   localparam int RW = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          byte_vld,
   input  logic [7:0]    byte_dat,
   input  logic          sel_data,
   output logic [CW-1:0] col_lo,
   output logic [CW-1:0] col_hi,
   output logic [RW-1:0] row_lo,
   output logic [RW-1:0] row_hi,
   output logic [7:0]    remap,
   output logic          vert_inc,
   output logic          col_load,
   output logic          row_load,
   output logic          bad_op
);
   generate
      if (COLS < 2 || COLS > 256) begin : g_bad_cols
         $error("COLS must lie in 2..256");
      end
      if (ROWS < 2 || ROWS > 256) begin : g_bad_rows
         $error("ROWS must lie in 2..256");
      end
      if (VERT_BIT < 0 || VERT_BIT > 7) begin : g_bad_bit
         $error("VERT_BIT must lie in 0..7");
      end
   endgenerate

   logic       commit;
   op_kind_t   ckind;
   logic [7:0] arg_a, arg_b;

   dcp_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_vld    (byte_vld),
      .byte_dat    (byte_dat),
      .sel_data    (sel_data),
      .commit      (commit),
      .commit_kind (ckind),
      .arg_a       (arg_a),
      .arg_b       (arg_b),
      .bad_op      (bad_op)
   );

   dcp_regs #(.COLS(COLS), .ROWS(ROWS), .VERT_BIT(VERT_BIT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .kind     (ckind),
      .arg_a    (arg_a),
      .arg_b    (arg_b),
      .col_lo   (col_lo),
      .col_hi   (col_hi),
      .row_lo   (row_lo),
      .row_hi   (row_hi),
      .remap    (remap),
      .vert_inc (vert_inc),
      .col_load (col_load),
      .row_load (row_load)
   );

   // R10
   data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_data |=> !(col_load || row_load));
endmodule

// File: tb/sim_dcp_parser.sv
`timescale 1ns/1ps
module sim_dcp_parser;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_dat = '0;
   logic       sel_data = 1'b0;
   logic [5:0] col_lo, col_hi;
   logic [6:0] row_lo, row_hi;
   logic [7:0] remap;
   logic       vert_inc, col_load, row_load, bad_op;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   dcp_parser u0 (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
      .sel_data(sel_data), .col_lo(col_lo), .col_hi(col_hi),
      .row_lo(row_lo), .row_hi(row_hi), .remap(remap), .vert_inc(vert_inc),
      .col_load(col_load), .row_load(row_load), .bad_op(bad_op)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic put(input logic sel, input logic [7:0] b);
      @(negedge clk);
      sel_data = sel;
      byte_vld = 1'b1;
      byte_dat = b;
      @(negedge clk);
      byte_vld = 1'b0;
      sel_data = 1'b0;
   endtask

   task automatic set_remap(input logic [7:0] v);
      put(0, 8'hA0);
      put(0, v);
   endtask

   task automatic t_reset();
      chk("R1 col_lo", col_lo, 0);
      chk("R1 col_hi", col_hi, 63);
      chk("R1 row_lo", row_lo, 0);
      chk("R1 row_hi", row_hi, 79);
      chk("R1 remap", remap, 0);
      chk("R1 strobes", {col_load, row_load}, 0);
      chk("R1 bad_op", bad_op, 0);
   endtask

   task automatic t_col(input logic [7:0] a, input logic [7:0] b);
      put(0, 8'h15); put(0, a);
      chk("R2 no early strobe", col_load, 0);
      put(0, b);
      chk("R2 col_lo", col_lo, a % 64);
      chk("R2 col_hi", col_hi, b % 64);
      chk("R2 col_load", col_load, 1);
      @(negedge clk);
      chk("R11 col pulse", col_load, 0);
   endtask

   task automatic t_row(input logic [7:0] a, input logic [7:0] b);
      put(0, 8'h75); put(0, a); put(0, b);
      chk("R3 row_lo", row_lo, a % 80);
      chk("R3 row_hi", row_hi, b % 80);
      chk("R3 row_load", row_load, 1);
      @(negedge clk);
      chk("R11 row pulse", row_load, 0);
   endtask

   task automatic t_remap(input logic [7:0] v);
      set_remap(v);
      chk("R4 remap", remap, v);
      chk("R4 vert_inc", vert_inc, v[2]);
   endtask

   task automatic t_one_arg();
      logic [7:0] ops [11] = '{8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1,
                               8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF};
      for (int i = 0; i < 11; i++) begin
         put(0, ops[i]);
         put(0, 8'h15);
         set_remap(8'(i + 16));
         chk("R5 remap after skip", remap, i + 16);
         chk("R5 col unchanged", {col_lo, col_hi}, {6'd5, 6'd9});
      end
   endtask

   task automatic t_eight();
      put(0, 8'hB8);
      for (int i = 0; i < 8; i++) put(0, (i % 2 == 0) ? 8'hA0 : 8'h15);
      set_remap(8'h33);
      chk("R6 remap", remap, 8'h33);
      chk("R6 col unchanged", {col_lo, col_hi}, {6'd5, 6'd9});
   endtask

   task automatic t_zero();
      logic [7:0] ops [10] = '{8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6,
                               8'hA7, 8'hAE, 8'hAF, 8'hE3};
      for (int i = 0; i < 10; i++) begin
         put(0, ops[i]);
         set_remap(8'(i + 64));
         chk("R7 remap after no-arg op", remap, i + 64);
      end
      chk("R7 bad_op low", bad_op, 0);
   endtask

   task automatic t_ff();
      put(0, 8'hFF);
      set_remap(8'h0B);
      chk("R8 remap", remap, 8'h0B);
      chk("R8 bad_op low", bad_op, 0);
   endtask

   task automatic t_unknown();
      put(0, 8'h00);
      chk("R9 bad_op set", bad_op, 1);
      set_remap(8'h2C);
      chk("R9 next is opcode", remap, 8'h2C);
      chk("R9 bad_op sticky", bad_op, 1);
   endtask

   task automatic t_abort();
      put(0, 8'h15); put(0, 8'h03);
      put(1, 8'hA0); put(1, 8'h77);
      set_remap(8'h01);
      chk("R10 remap after abort", remap, 8'h01);
      chk("R10 col unchanged", {col_lo, col_hi}, {6'd5, 6'd9});
      put(1, 8'h15); put(1, 8'h02); put(1, 8'h03);
      chk("R10 data bytes ignored", {col_lo, col_hi, col_load}, {6'd5, 6'd9, 1'b0});
      chk("R10 remap kept", remap, 8'h01);
   endtask

   initial begin : watchdog
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected 0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_col(8'd200, 8'd70);
      t_row(8'd255, 8'd85);
      t_row(8'd10, 8'd79);
      t_col(8'd5, 8'd9);
      t_remap(8'h04);
      t_remap(8'hFB);
      t_one_arg();
      t_eight();
      t_zero();
      t_ff();
      t_unknown();
      t_abort();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule